// File: doc/BRIEF.md
# Single-Wire Slave Transaction Engine

This block sits between the bit-level receiver/driver of a single-wire, pulse-width-encoded sensor bus and a small register file. The bit layer hands it one decoded symbol at a time: a data zero, a data one, a start marker or a bus reset. The engine frames these symbols into register transactions. After a start marker it gathers a header: the 3-bit device number, then the 6-bit register index, then the direction flag. The data field follows, and a parity bit and an acknowledge bit close the transaction.

On a read the engine supplies the data bits and the parity bit for each slot the master opens. On a write it collects the data and checks the parity. It then answers in the acknowledge slot, and it commits the write to the register file only when that slot reads back as a one. Transactions for other device numbers are ignored. A broadcast device number is honoured only for a write to the control register, and that write touches only the two lowest bits. Any failed acknowledge raises a one-cycle bus-error event for the status logic.

The register file tells the engine how wide the addressed register is (8 or 16 bits). A start marker abandons any transaction in flight without complaint. A reset symbol sends the engine back to waiting for a start marker and leaves every register unchanged.

Top module: `swt_txn_engine`

## Requirements
- R1: Symbols arrive on `sym_code` qualified by `sym_vld`, coded 0 = data zero, 1 = data one, 2 = start, 3 = bus reset. After a start, the first 10 data bits form the header, sent most significant bit first. The header is the device number (3 bits), then the register index (6 bits), then the direction flag (1 = read, 0 = write). A header whose device number is neither the own number nor broadcast (000) leaves `drv_en` low for the rest of the transaction and commits nothing.
- R2: The own device number is the 2-bit strap value plus one: 00→001, 01→010, 10→011, 11→100.
- R3: On an accepted read, `drv_en` is high in each data slot and in the parity slot. `drv_bit` presents the register value most significant bit first: 16 bits when `reg_wide` is 1, otherwise the low 8 bits. The parity slot then carries the bit that makes the ones across header, data and parity even.
- R4: On an accepted write, the engine checks even parity over header, data and the received parity bit. In the acknowledge slot it drives `drv_en` = 1, with `drv_bit` = 1 if the parity is correct and 0 if it is wrong.
- R5: A write commits only when the acknowledge slot is observed as data one. The commit is a single-cycle `reg_we` pulse one clock after that symbol. It carries `reg_addr`, `reg_wdata` and `reg_wmask`, where the mask is 0x00FF for an 8-bit register and 0xFFFF for a 16-bit one.
- R6: When the acknowledge slot of an accepted transaction is observed as data zero, `berr_evt` pulses for one cycle one clock later and no write is committed. On a read this is the master's negative acknowledge.
- R7: A broadcast read is ignored and never drives. A broadcast write is accepted only for register index CTRL_ADDR (default 5), and it commits with mask 0x0003.
- R8: A start symbol in any state abandons the current transaction without raising `berr_evt` or `reg_we`, and begins collecting a new header.
- R9: A reset symbol returns the engine to idle. `drv_en` is low from the next cycle, and data bits are ignored until the next start. Register contents are untouched.
- R10: With fewer data bits than the register width, the engine waits with no time limit. With more, the bit after the expected width is taken as parity and the next as acknowledge. Later data bits are ignored until a start.
- R11: After reset, `drv_en`, `reg_we` and `berr_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap | input | 2 | Device number strap inputs |
| sym_vld | input | 1 | A decoded symbol is present this cycle |
| sym_code | input | 2 | Symbol code (0 data zero, 1 data one, 2 start, 3 reset) |
| drv_en | output | 1 | Engine owns the current bit slot |
| drv_bit | output | 1 | Value the engine sends in an owned slot |
| reg_addr | output | 6 | Register index of the current transaction |
| reg_wdata | output | 16 | Write data, valid with reg_we |
| reg_wmask | output | 16 | Bit mask of the write, valid with reg_we |
| reg_we | output | 1 | Single-cycle write commit strobe |
| reg_rdata | input | 16 | Read value of the register at reg_addr |
| reg_wide | input | 1 | Register at reg_addr is 16 bits wide |
| berr_evt | output | 1 | Single-cycle bus-error event |

## Verification
After the tenth header bit, the engine spends one cycle fetching the register and is driving by the second clock. `drv_en` and `drv_bit` for every later slot are settled one clock after the previous symbol. `reg_we` and `berr_evt` rise exactly one clock after the acknowledge symbol. The bench spaces symbols four clocks apart and samples the drive outputs on the falling edge just before it issues each slot. It counts commit and error pulses on falling edges, so each pulse is caught within its single-cycle window, and it compares the counts before and after each transaction.

// File: rtl/swt_pkg.sv
// Shared symbol codes and frame states of the single-wire transaction engine.
// Assumes the bit layer presents at most one symbol per clock.
package swt_pkg;

    localparam logic [1:0] SYM_D0    = 2'b00;
    localparam logic [1:0] SYM_D1    = 2'b01;
    localparam logic [1:0] SYM_START = 2'b10;
    localparam logic [1:0] SYM_RESET = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_LOAD = 3'd2,
        ST_DATA = 3'd3,
        ST_PAR  = 3'd4,
        ST_ACK  = 3'd5
    } st_e;

endpackage

// File: rtl/swt_devnum.sv
// Own device number from the strap pins: strap value plus one.
// Assumes DEV_W is wide enough to hold 2**STRAP_W.
module swt_devnum #(
    parameter int STRAP_W = 2,
    parameter int DEV_W   = 3
) (
    input  logic [STRAP_W-1:0] strap,
    output logic [DEV_W-1:0]   own_dev
);

    // map strap code to device number 1..2**STRAP_W
    always_comb begin
        own_dev = DEV_W'(strap) + DEV_W'(1);
    end

endmodule

// File: rtl/swt_frame_ctl.sv
// Frame sequencer: header collection, address decode, data/parity/ack slot
// counting, commit and bus-error decisions.
// Assumes symbols are at least two clocks apart so the LOAD cycle fits.
module swt_frame_ctl
    import swt_pkg::*;
#(
    parameter int              DEV_W     = 3,
    parameter int              ADDR_W    = 6,
    parameter int              DATA_W    = 16,
    parameter int              NARROW_W  = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_vld,
    input  logic [1:0]        sym_code,
    input  logic [DEV_W-1:0]  own_dev,
    input  logic              reg_wide,
    input  logic              par_ok,
    output st_e               st_o,
    output logic              rd_q,
    output logic              bcast_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wide_q,
    output logic              hdr_bit_en,
    output logic              data_bit_en,
    output logic              load_en,
    output logic              clr_en,
    output logic              par_bit_en,
    output logic              commit_q,
    output logic              berr_q
);

    localparam int HDR_W  = DEV_W + ADDR_W + 1;
    localparam int HCNT_W = $clog2(HDR_W + 1);
    localparam int DCNT_W = $clog2(DATA_W + 1);

    st_e                 st;
    logic [HDR_W-2:0]    hdr_q;
    logic [HDR_W-1:0]    hdr_nx;
    logic [HCNT_W-1:0]   hcnt;
    logic [DCNT_W-1:0]   dcnt;
    logic [DCNT_W-1:0]   last_idx;
    logic                bit_vld;
    logic                bit_val;
    logic                is_start;
    logic                is_rst;
    logic [DEV_W-1:0]    dev_nx;
    logic [ADDR_W-1:0]   addr_nx;
    logic                rw_nx;
    logic                accept;

    // classify the incoming symbol
    always_comb begin
        bit_vld  = sym_vld && !sym_code[1];
        bit_val  = sym_code[0];
        is_start = sym_vld && (sym_code == SYM_START);
        is_rst   = sym_vld && (sym_code == SYM_RESET);
    end

    // header fields as they stand once the current bit is included
    always_comb begin
        hdr_nx  = {hdr_q, bit_val};
        dev_nx  = hdr_nx[HDR_W-1 -: DEV_W];
        addr_nx = hdr_nx[ADDR_W:1];
        rw_nx   = hdr_nx[0];
        if (rw_nx)
            accept = (dev_nx == own_dev);
        else
            accept = (dev_nx == own_dev) ||
                     ((dev_nx == '0) && (addr_nx == CTRL_ADDR));
    end

    // index of the final data bit for the register size latched at LOAD
    always_comb begin
        last_idx = wide_q ? DCNT_W'(DATA_W - 1) : DCNT_W'(NARROW_W - 1);
    end

    // per-cycle strobes for the datapath
    always_comb begin
        hdr_bit_en  = (st == ST_HDR)  && bit_vld && !is_start;
        data_bit_en = (st == ST_DATA) && bit_vld;
        load_en     = (st == ST_LOAD) && !is_start && !is_rst;
        clr_en      = is_start;
        par_bit_en  = (st == ST_PAR)  && bit_vld && !rd_q;
        st_o        = st;
    end

    // frame state, counters and one-cycle result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            hdr_q    <= '0;
            hcnt     <= '0;
            dcnt     <= '0;
            rd_q     <= 1'b0;
            bcast_q  <= 1'b0;
            addr_q   <= '0;
            wide_q   <= 1'b0;
            commit_q <= 1'b0;
            berr_q   <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            berr_q   <= 1'b0;
            if (is_rst) begin
                st <= ST_IDLE;
            end else if (is_start) begin
                st   <= ST_HDR;
                hcnt <= '0;
            end else begin
                case (st)
                    ST_HDR: begin
                        if (bit_vld) begin
                            hdr_q <= hdr_nx[HDR_W-2:0];
                            hcnt  <= hcnt + HCNT_W'(1);
                            if (hcnt == HCNT_W'(HDR_W - 1)) begin
                                rd_q    <= rw_nx;
                                bcast_q <= (dev_nx == '0);
                                addr_q  <= addr_nx;
                                st      <= accept ? ST_LOAD : ST_IDLE;
                            end
                        end
                    end
                    ST_LOAD: begin
                        wide_q <= reg_wide;
                        dcnt   <= '0;
                        st     <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (bit_vld) begin
                            dcnt <= dcnt + DCNT_W'(1);
                            if (dcnt == last_idx)
                                st <= ST_PAR;
                        end
                    end
                    ST_PAR: begin
                        if (bit_vld)
                            st <= ST_ACK;
                    end
                    ST_ACK: begin
                        if (bit_vld) begin
                            st <= ST_IDLE;
                            if (rd_q) begin
                                berr_q <= !bit_val;
                            end else begin
                                commit_q <= par_ok && bit_val;
                                berr_q   <= !(par_ok && bit_val);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/swt_datapath.sv
// Shared data shift register and running even-parity accumulator.
// Read data is loaded MSB-aligned and shifted out; write data is shifted in
// so an 8-bit value ends in the low byte. Parity covers every bus bit seen.
module swt_datapath #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic              hdr_bit_en,
    input  logic              data_bit_en,
    input  logic              load_en,
    input  logic              par_bit_en,
    input  logic              bit_val,
    input  logic              reg_wide,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] sh_q,
    output logic              acc_q,
    output logic              par_ok_q
);

    localparam int PAD_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] load_val;

    // align a narrow register to the top of the shifter
    always_comb begin
        load_val = reg_wide ? reg_rdata : (reg_rdata << PAD_W);
    end

    // shift register: load for reads, shift on every data bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load_en)
            sh_q <= load_val;
        else if (data_bit_en)
            sh_q <= {sh_q[DATA_W-2:0], bit_val};
    end

    // running parity and parity verdict for writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= 1'b0;
            par_ok_q <= 1'b0;
        end else if (clr_en) begin
            acc_q    <= 1'b0;
            par_ok_q <= 1'b0;
        end else if (hdr_bit_en || data_bit_en) begin
            acc_q <= acc_q ^ bit_val;
        end else if (par_bit_en) begin
            par_ok_q <= !(acc_q ^ bit_val);
        end
    end

endmodule

// File: rtl/swt_txn_engine.sv
// Top of the single-wire slave transaction engine. Frames symbols from the
// bit layer into register reads and writes, drives owned bit slots, commits
// acknowledged writes and reports bus errors.
// Assumes a register file answering reg_rdata/reg_wide combinationally
// from reg_addr, and symbols spaced at least two clocks apart.
module swt_txn_engine
    import swt_pkg::*;
#(
    parameter int                STRAP_W    = 2,
    parameter int                DEV_W      = 3,
    parameter int                ADDR_W     = 6,
    parameter int                DATA_W     = 16,
    parameter int                NARROW_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 6'd5,
    parameter logic [DATA_W-1:0] BCAST_MASK = 16'h0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               sym_vld,
    input  logic [1:0]         sym_code,
    output logic               drv_en,
    output logic               drv_bit,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_wmask,
    output logic               reg_we,
    input  logic [DATA_W-1:0]  reg_rdata,
    input  logic               reg_wide,
    output logic               berr_evt
);

    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [DEV_W-1:0]  own_dev;
    st_e               st;
    logic              rd_q;
    logic              bcast_q;
    logic              wide_q;
    logic              hdr_bit_en;
    logic              data_bit_en;
    logic              load_en;
    logic              clr_en;
    logic              par_bit_en;
    logic              commit_q;
    logic              berr_q;
    logic [DATA_W-1:0] sh_q;
    logic              acc_q;
    logic              par_ok_q;

    swt_devnum #(
        .STRAP_W (STRAP_W),
        .DEV_W   (DEV_W)
    ) i_devnum (
        .strap   (strap),
        .own_dev (own_dev)
    );

    swt_frame_ctl #(
        .DEV_W     (DEV_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NARROW_W  (NARROW_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) i_frame_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_vld     (sym_vld),
        .sym_code    (sym_code),
        .own_dev     (own_dev),
        .reg_wide    (reg_wide),
        .par_ok      (par_ok_q),
        .st_o        (st),
        .rd_q        (rd_q),
        .bcast_q     (bcast_q),
        .addr_q      (reg_addr),
        .wide_q      (wide_q),
        .hdr_bit_en  (hdr_bit_en),
        .data_bit_en (data_bit_en),
        .load_en     (load_en),
        .clr_en      (clr_en),
        .par_bit_en  (par_bit_en),
        .commit_q    (commit_q),
        .berr_q      (berr_q)
    );

    swt_datapath #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) i_datapath (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_en      (clr_en),
        .hdr_bit_en  (hdr_bit_en),
        .data_bit_en (data_bit_en),
        .load_en     (load_en),
        .par_bit_en  (par_bit_en),
        .bit_val     (sym_code[0]),
        .reg_wide    (reg_wide),
        .reg_rdata   (reg_rdata),
        .sh_q        (sh_q),
        .acc_q       (acc_q),
        .par_ok_q    (par_ok_q)
    );

    // slot ownership: data and parity on reads, acknowledge on writes
    always_comb begin
        drv_en  = 1'b0;
        drv_bit = 1'b0;
        case (st)
            ST_DATA: begin
                drv_en  = rd_q;
                drv_bit = rd_q && sh_q[DATA_W-1];
            end
            ST_PAR: begin
                drv_en  = rd_q;
                drv_bit = rd_q && acc_q;
            end
            ST_ACK: begin
                drv_en  = !rd_q;
                drv_bit = !rd_q && par_ok_q;
            end
            default: ;
        endcase
    end

    // register-file write port and error event
    always_comb begin
        reg_we    = commit_q;
        reg_wdata = sh_q;
        reg_wmask = bcast_q ? BCAST_MASK : (wide_q ? '1 : NARROW_MASK);
        berr_evt  = berr_q;
    end

endmodule

// File: rtl/swt_txn_chk.sv
// Protocol checker for swt_txn_engine, attached by bind.
// Relates symbols seen at the input to the commit, error and drive outputs.
module swt_txn_chk
    import swt_pkg::*;
#(
    parameter int                DATA_W     = 16,
    parameter int                NARROW_W   = 8,
    parameter logic [DATA_W-1:0] BCAST_MASK = 16'h0003
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_vld,
    input logic [1:0]        sym_code,
    input logic              drv_en,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wmask,
    input logic              berr_evt
);

    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    // R5
    wr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(sym_vld && (sym_code == SYM_D1)));

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6
    berr_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berr_evt |-> $past(sym_vld && !sym_code[1]));

    // R6
    we_berr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && berr_evt));

    // R8
    start_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && (sym_code == SYM_START)) |=> (!berr_evt && !reg_we));

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && (sym_code == SYM_RESET)) |=> !drv_en);

    // R7
    mask_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ((reg_wmask == NARROW_MASK) || (reg_wmask == '1) ||
                    (reg_wmask == BCAST_MASK)));

endmodule

bind swt_txn_engine swt_txn_chk #(
    .DATA_W     (DATA_W),
    .NARROW_W   (NARROW_W),
    .BCAST_MASK (BCAST_MASK)
) i_swt_txn_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_vld   (sym_vld),
    .sym_code  (sym_code),
    .drv_en    (drv_en),
    .reg_we    (reg_we),
    .reg_wmask (reg_wmask),
    .berr_evt  (berr_evt)
);

// File: tb/test_swt_txn_engine.sv
// Directed bench: a master model issues symbol slots, a register-file model
// answers reads and applies commits; each scenario task checks its results.
module test_swt_txn_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  strap;
    logic        sym_vld;
    logic [1:0]  sym_code;
    logic        drv_en;
    logic        drv_bit;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_wmask;
    logic        reg_we;
    logic [15:0] reg_rdata;
    logic        reg_wide;
    logic        berr_evt;

    int n_chk = 0;
    int n_err = 0;
    int we_cnt = 0;
    int berr_cnt = 0;
    logic [15:0] last_mask;
    logic [15:0] mem [0:63];
    bit done = 1'b0;

    logic [63:0] g_en, g_bit, g_bus;
    int g_n;
    int gap_we, gap_berr;
    logic gap_drv;

    always #10 clk = ~clk;

    swt_txn_engine i_swt_txn_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap),
        .sym_vld   (sym_vld),
        .sym_code  (sym_code),
        .drv_en    (drv_en),
        .drv_bit   (drv_bit),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wmask (reg_wmask),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .reg_wide  (reg_wide),
        .berr_evt  (berr_evt)
    );

    // register-file model: index 2 is 16 bits, all others 8 bits
    assign reg_rdata = mem[reg_addr];
    assign reg_wide  = (reg_addr == 6'd2);

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 16'h0;
        end else begin
            if (reg_we) begin
                mem[reg_addr] <= (mem[reg_addr] & ~reg_wmask) | (reg_wdata & reg_wmask);
                last_mask <= reg_wmask;
                we_cnt <= we_cnt + 1;
            end
            if (berr_evt) berr_cnt <= berr_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ctl_sym(input logic [1:0] code);
        @(negedge clk);
        sym_vld = 1'b1;
        sym_code = code;
        @(negedge clk);
        sym_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // one data slot: the bus shows a one if either side sends a one
    task automatic slot(input logic mbit);
        logic b;
        @(negedge clk);
        g_en[g_n]  = drv_en;
        g_bit[g_n] = drv_bit;
        b = mbit | (drv_en & drv_bit);
        g_bus[g_n] = b;
        g_n++;
        sym_vld = 1'b1;
        sym_code = {1'b0, b};
        @(negedge clk);
        sym_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic header(input logic [2:0] dev, input logic [5:0] addr, input logic rd);
        logic [9:0] h;
        h = {dev, addr, rd};
        ctl_sym(2'd2);
        g_n = 0; g_en = '0; g_bit = '0; g_bus = '0;
        for (int i = 9; i >= 0; i--) slot(h[i]);
    endtask

    // full transaction; gap_after >= 0 pauses after that many data bits
    task automatic xfer(input logic [2:0] dev, input logic [5:0] addr, input logic rd,
                        input logic [15:0] data, input int nbits, input logic bad_par,
                        input logic mack, input int gap_after);
        logic par;
        int sent;
        par = ^{dev, addr, rd};
        sent = 0;
        header(dev, addr, rd);
        for (int i = nbits - 1; i >= 0; i--) begin
            if (sent == gap_after) begin
                repeat (500) @(negedge clk);
                gap_we = we_cnt; gap_berr = berr_cnt; gap_drv = drv_en;
            end
            slot(rd ? 1'b0 : data[i]);
            par = par ^ g_bus[g_n-1];
            sent++;
        end
        slot(rd ? 1'b0 : (par ^ bad_par));
        slot(rd ? mack : 1'b0);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] bus_bits(input int first, input int n);
        logic [15:0] v = '0;
        for (int k = 0; k < n; k++) v = {v[14:0], g_bus[first+k]};
        return v;
    endfunction

    task automatic t_reset_state();
        chk("R11 drv_en after reset", {31'b0, drv_en}, 0);
        chk("R11 reg_we after reset", {31'b0, reg_we}, 0);
        chk("R11 berr_evt after reset", {31'b0, berr_evt}, 0);
    endtask

    task automatic t_write_ok();
        int w0 = we_cnt, b0 = berr_cnt;
        xfer(3'd2, 6'd1, 1'b0, 16'h00A5, 8, 1'b0, 1'b0, -1);
        chk("R1 no drive during header", {22'b0, g_en[9:0]}, 0);
        chk("R4 ack slot driven", {30'b0, g_en[19], g_bit[19]}, 2'b11);
        chk("R5 commit count", we_cnt - w0, 1);
        chk("R5 written value", mem[1], 16'h00A5);
        chk("R5 narrow mask", last_mask, 16'h00FF);
        chk("R6 no error on good write", berr_cnt - b0, 0);
        w0 = we_cnt;
        xfer(3'd2, 6'd2, 1'b0, 16'hBEEF, 16, 1'b0, 1'b0, -1);
        chk("R5 wide commit", we_cnt - w0, 1);
        chk("R5 wide value", mem[2], 16'hBEEF);
        chk("R5 wide mask", last_mask, 16'hFFFF);
    endtask

    task automatic t_bad_parity();
        int w0 = we_cnt, b0 = berr_cnt;
        xfer(3'd2, 6'd1, 1'b0, 16'h003C, 8, 1'b1, 1'b0, -1);
        chk("R4 nack driven on bad parity", {30'b0, g_en[19], g_bit[19]}, 2'b10);
        chk("R6 error on bad parity", berr_cnt - b0, 1);
        chk("R5 no commit on bad parity", we_cnt - w0, 0);
        chk("R5 register kept", mem[1], 16'h00A5);
    endtask

    task automatic t_reads();
        int b0 = berr_cnt;
        logic [9:0] h;
        xfer(3'd2, 6'd2, 1'b1, 16'h0, 16, 1'b0, 1'b1, -1);
        h = {3'd2, 6'd2, 1'b1};
        chk("R3 wide read data", bus_bits(10, 16), 16'hBEEF);
        chk("R3 data slots driven", {16'b0, g_en[25:10]}, 32'h0000FFFF);
        chk("R3 parity slot", {30'b0, g_en[26], g_bit[26]}, {30'b0, 1'b1, ^{h, 16'hBEEF}});
        chk("R6 no error on acked read", berr_cnt - b0, 0);
        xfer(3'd2, 6'd1, 1'b1, 16'h0, 8, 1'b0, 1'b0, -1);
        h = {3'd2, 6'd1, 1'b1};
        chk("R3 narrow read data", bus_bits(10, 8), 16'h00A5);
        chk("R3 narrow parity", {31'b0, g_bit[18]}, {31'b0, ^{h, 8'hA5}});
        chk("R6 error on read nack", berr_cnt - b0, 1);
    endtask

    task automatic t_other_dev();
        int w0 = we_cnt;
        xfer(3'd3, 6'd1, 1'b0, 16'h0011, 8, 1'b0, 1'b0, -1);
        chk("R1 foreign write never drives", g_en[31:0], 0);
        chk("R1 foreign write not committed", we_cnt - w0, 0);
        xfer(3'd5, 6'd2, 1'b1, 16'h0, 16, 1'b0, 1'b1, -1);
        chk("R1 foreign read never drives", g_en[31:0], 0);
    endtask

    task automatic t_broadcast();
        int w0 = we_cnt;
        xfer(3'd0, 6'd5, 1'b0, 16'h00FF, 8, 1'b0, 1'b0, -1);
        chk("R7 broadcast ctrl write commits", we_cnt - w0, 1);
        chk("R7 broadcast mask", last_mask, 16'h0003);
        chk("R7 broadcast ctrl value", mem[5], 16'h0003);
        w0 = we_cnt;
        xfer(3'd0, 6'd1, 1'b0, 16'h0000, 8, 1'b0, 1'b0, -1);
        chk("R7 broadcast other write ignored", we_cnt - w0, 0);
        chk("R7 register kept", mem[1], 16'h00A5);
        xfer(3'd0, 6'd1, 1'b1, 16'h0, 8, 1'b0, 1'b1, -1);
        chk("R7 broadcast read never drives", g_en[31:0], 0);
    endtask

    task automatic t_start_abort();
        int w0 = we_cnt, b0 = berr_cnt;
        header(3'd2, 6'd1, 1'b0);
        for (int i = 0; i < 4; i++) slot(1'b1);
        xfer(3'd2, 6'd1, 1'b0, 16'h005A, 8, 1'b0, 1'b0, -1);
        chk("R8 abort raises no error", berr_cnt - b0, 0);
        chk("R8 new transaction commits once", we_cnt - w0, 1);
        chk("R8 new value", mem[1], 16'h005A);
    endtask

    task automatic t_reset_sym();
        int w0 = we_cnt, b0 = berr_cnt;
        header(3'd2, 6'd2, 1'b1);
        slot(1'b0);
        ctl_sym(2'd3);
        chk("R9 no drive after reset symbol", {31'b0, drv_en}, 0);
        for (int i = 0; i < 17; i++) slot(1'b0);
        chk("R9 later bits not driven", g_en[31:11], 0);
        chk("R9 no commit or error", (we_cnt - w0) + (berr_cnt - b0), 0);
        chk("R9 registers untouched", mem[2], 16'hBEEF);
    endtask

    task automatic t_bit_count();
        int w0 = we_cnt, b0 = berr_cnt;
        xfer(3'd2, 6'd2, 1'b0, 16'h1357, 16, 1'b0, 1'b0, 8);
        chk("R10 waits on short field", (gap_we - w0) + (gap_berr - b0), 0);
        chk("R10 no drive while waiting", {31'b0, gap_drv}, 0);
        chk("R10 completes after missing bits", mem[2], 16'h1357);
        w0 = we_cnt; b0 = berr_cnt;
        xfer(3'd2, 6'd1, 1'b0, 16'h0002, 10, 1'b0, 1'b0, -1);
        chk("R10 extra bit taken as ack slot", {30'b0, g_en[19], g_bit[19]}, 2'b10);
        chk("R10 bits after ack ignored", {30'b0, g_en[21:20]}, 0);
        chk("R10 one error, no commit", {berr_cnt - b0, we_cnt - w0}, {32'd1, 32'd0});
        chk("R10 register kept", mem[1], 16'h005A);
    endtask

    task automatic t_strap();
        int w0;
        strap = 2'b11;
        repeat (2) @(negedge clk);
        xfer(3'd4, 6'd1, 1'b0, 16'h0077, 8, 1'b0, 1'b0, -1);
        chk("R2 strap 11 answers to 100", mem[1], 16'h0077);
        w0 = we_cnt;
        xfer(3'd2, 6'd1, 1'b0, 16'h0099, 8, 1'b0, 1'b0, -1);
        chk("R2 old number no longer answered", we_cnt - w0, 0);
        strap = 2'b00;
        repeat (2) @(negedge clk);
        xfer(3'd1, 6'd3, 1'b0, 16'h0042, 8, 1'b0, 1'b0, -1);
        chk("R2 strap 00 answers to 001", mem[3], 16'h0042);
        strap = 2'b10;
        repeat (2) @(negedge clk);
        xfer(3'd3, 6'd3, 1'b1, 16'h0, 8, 1'b0, 1'b1, -1);
        chk("R2 strap 10 answers to 011", bus_bits(10, 8), 16'h0042);
    endtask

    initial begin
        rst_n = 1'b0;
        strap = 2'b01;
        sym_vld = 1'b0;
        sym_code = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_write_ok();
        t_bad_parity();
        t_reads();
        t_other_dev();
        t_broadcast();
        t_start_abort();
        t_reset_sym();
        t_bit_count();
        t_strap();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule